// File: doc/BRIEF.md
# Received Word Acceptance Filter

This block stands between the serial receive front end of an avionics data bus receiver and its receive FIFO. When the front end presents a complete 32-bit word with a one-cycle end-of-word strobe, the filter decides whether the word is kept. Two checks can be switched on, each on its own. The first compares the word's 8-bit label against a small programmable table. The second compares the two bits that follow the label against a programmed pair. A word that fails any check that is switched on is dropped without any indication.

Every word that is kept has its top bit replaced by a parity-error flag before it goes to the FIFO. The flag is 0 when the incoming word had odd parity and 1 when it had even parity. The label table is loaded and read back through a pointer that steps by one on each strobe. The table can only be reached while a label-mode input is held high.

Bit numbering: `word_in[0]` is serial bit 1 and `word_in[31]` is serial bit 32. The label is `word_in[7:0]`. Serial bit 9 is `word_in[8]` and serial bit 10 is `word_in[9]`.

Top module: `arinc_word_filter`

## Requirements
- R1: The label table holds 16 entries of 8 bits, all 0x00 after reset. While `lbl_mode` is 1, a `lbl_wr` pulse writes `lbl_wdata` into the entry at the pointer and advances the pointer by one. After entry 15 the pointer wraps to entry 0.
- R2: `lbl_rdata` always shows the entry at the pointer. While `lbl_mode` is 1, a `lbl_rd` pulse advances the pointer by one.
- R3: The pointer is 0 after reset. It also returns to 0 in the first clock in which `lbl_mode` is seen high after being low.
- R4: While `lbl_mode` is 0, `lbl_wr` and `lbl_rd` have no effect: neither the table nor the pointer changes.
- R5: With `label_chk_en`=1, a word is kept only if `word_in[7:0]` equals one of the 16 entries. The comparison uses the table contents as they stand before any write in the same clock. With `label_chk_en`=0 the label is not checked.
- R6: With `decode_en`=1, a word is kept only if `word_in[8]`==`decode_bits[0]` and `word_in[9]`==`decode_bits[1]`. With `decode_en`=0 these bits are not checked.
- R7: When both checks are enabled, a word is kept only if both pass. A dropped word produces no FIFO write.
- R8: A kept word is written with bits 30..0 unchanged. Bit 31 is set to 0 if the 32 incoming bits have odd parity and to 1 if they have even parity.
- R9: `fifo_wr` is a one-cycle pulse in the clock after the `word_eos` cycle, and `fifo_data` is valid with it. Word filtering continues while `lbl_mode` is 1.
- R10: No write is issued for a word whose `word_eos` cycle sees `fifo_full`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_in | input | 32 | Received word, serial bit 1 at index 0 |
| word_eos | input | 1 | One-cycle strobe: `word_in` holds a complete word |
| label_chk_en | input | 1 | Enable the label table check |
| decode_en | input | 1 | Enable the check of serial bits 9 and 10 |
| decode_bits | input | 2 | Required values: [0] for bit 9, [1] for bit 10 |
| lbl_mode | input | 1 | Label table access mode |
| lbl_wr | input | 1 | Label write strobe |
| lbl_rd | input | 1 | Label read-advance strobe |
| lbl_wdata | input | 8 | Label to write |
| lbl_rdata | output | 8 | Entry at the pointer |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write pulse |
| fifo_data | output | 32 | Word to store, bit 31 is the parity-error flag |

## Verification
A label write and a word decision can fall in the same clock, because filtering keeps running in label mode. The bench provokes this by writing a new label while a word carrying that same label is strobed, with the label check enabled. The word must be dropped, since it is judged against the table before the write. An identical word strobed afterwards must be kept. A scoreboard queue holds the expected stored words and compares each one against every FIFO write in order.

// File: rtl/arinc_filt_pkg.sv
`timescale 1ns/1ps
// Shared sizes and types for the received word acceptance filter.
package arinc_filt_pkg;
    localparam int WORD_BITS  = 32;
    localparam int LABEL_BITS = 8;
    localparam int TABLE_SIZE = 16;

    typedef logic [WORD_BITS-1:0]  word_t;
    typedef logic [LABEL_BITS-1:0] label_t;
endpackage

// File: rtl/label_store.sv
`timescale 1ns/1ps
// Label table with a stepping pointer.
// Assumes: strobes are single-cycle; they only act while mode_i is high.
// The pointer is cleared on reset and on the first clock of mode entry.
module label_store #(
    parameter int N_ENTRIES = 16,
    parameter int ENTRY_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mode_i,
    input  logic                              wr_i,
    input  logic                              rd_i,
    input  logic [ENTRY_W-1:0]                wdata_i,
    output logic [ENTRY_W-1:0]                rdata_o,
    output logic [N_ENTRIES-1:0][ENTRY_W-1:0] table_o
);
    localparam int PTR_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(N_ENTRIES - 1);

    logic             mode_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_use;
    logic             entering;
    logic             do_wr;
    logic             step;

    // Decode mode entry and effective strobes.
    always_comb begin
        entering = mode_i & ~mode_q;
        ptr_use  = entering ? '0 : ptr_q;
        do_wr    = mode_i & wr_i;
        step     = mode_i & (wr_i | rd_i);
    end

    // Track the previous mode level to find mode entry.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_i;
    end

    // Pointer: clear on entry, step with wrap on strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr_q <= '0;
        else if (step) ptr_q <= (ptr_use == LAST) ? '0 : ptr_use + 1'b1;
        else           ptr_q <= ptr_use;
    end

    // One register per entry, written when selected.
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                             table_o[i] <= '0;
            else if (do_wr && ptr_use == PTR_W'(i)) table_o[i] <= wdata_i;
        end
    end

    // Read port shows the entry at the pointer.
    assign rdata_o = table_o[ptr_q];
endmodule

// File: rtl/label_match.sv
`timescale 1ns/1ps
// Compares one label against every table entry at once.
// Assumes: the table is register outputs, so the result settles in one clock.
module label_match #(
    parameter int N_ENTRIES = 16,
    parameter int ENTRY_W   = 8
) (
    input  logic [ENTRY_W-1:0]                label_i,
    input  logic [N_ENTRIES-1:0][ENTRY_W-1:0] table_i,
    output logic                              hit_o
);
    logic [N_ENTRIES-1:0] eq;

    // Per-entry equality.
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign eq[i] = (table_i[i] == label_i);
    end

    // Any entry equal means a hit.
    assign hit_o = |eq;
endmodule

// File: rtl/word_check.sv
`timescale 1ns/1ps
// Combines the enabled checks into a keep decision and builds the stored word.
// Assumes: the two decode bits sit directly above the label field.
module word_check #(
    parameter int WORD_W  = 32,
    parameter int LABEL_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              label_en_i,
    input  logic              label_hit_i,
    input  logic              dec_en_i,
    input  logic [1:0]        dec_bits_i,
    output logic              keep_o,
    output logic [WORD_W-1:0] word_o
);
    logic label_ok;
    logic dec_ok;

    // Each check passes when it is disabled or when it matches.
    always_comb begin
        label_ok = ~label_en_i | label_hit_i;
        dec_ok   = ~dec_en_i | (word_i[LABEL_W+1:LABEL_W] == dec_bits_i);
        keep_o   = label_ok & dec_ok;
    end

    // Top bit becomes the parity-error flag: 1 when the parity is even.
    assign word_o = {~(^word_i), word_i[WORD_W-2:0]};
endmodule

// File: rtl/arinc_word_filter.sv
`timescale 1ns/1ps
// Received word acceptance filter.
// Decides per end-of-word strobe whether a word goes to the receive FIFO.
// Assumes: word_in is stable in the word_eos cycle, and fifo_full is
// sampled in that same cycle.
module arinc_word_filter
    import arinc_filt_pkg::*;
#(
    parameter int N_LABELS = TABLE_SIZE,
    parameter int LABEL_W  = LABEL_BITS,
    parameter int WORD_W   = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_eos,
    input  logic              label_chk_en,
    input  logic              decode_en,
    input  logic [1:0]        decode_bits,
    input  logic              lbl_mode,
    input  logic              lbl_wr,
    input  logic              lbl_rd,
    input  logic [LABEL_W-1:0] lbl_wdata,
    output logic [LABEL_W-1:0] lbl_rdata,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data
);
    logic [N_LABELS-1:0][LABEL_W-1:0] table_w;
    logic              hit;
    logic              keep;
    logic [WORD_W-1:0] fixed_word;

    label_store #(.N_ENTRIES(N_LABELS), .ENTRY_W(LABEL_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (lbl_mode),
        .wr_i    (lbl_wr),
        .rd_i    (lbl_rd),
        .wdata_i (lbl_wdata),
        .rdata_o (lbl_rdata),
        .table_o (table_w)
    );

    label_match #(.N_ENTRIES(N_LABELS), .ENTRY_W(LABEL_W)) u_match (
        .label_i (word_in[LABEL_W-1:0]),
        .table_i (table_w),
        .hit_o   (hit)
    );

    word_check #(.WORD_W(WORD_W), .LABEL_W(LABEL_W)) u_check (
        .word_i      (word_in),
        .label_en_i  (label_chk_en),
        .label_hit_i (hit),
        .dec_en_i    (decode_en),
        .dec_bits_i  (decode_bits),
        .keep_o      (keep),
        .word_o      (fixed_word)
    );

    // Issue the FIFO write one clock after the strobe of an accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
        end else begin
            fifo_wr <= word_eos & keep & ~fifo_full;
            if (word_eos && keep) fifo_data <= fixed_word;
        end
    end
endmodule

// File: rtl/arinc_word_filter_chk.sv
`timescale 1ns/1ps
// Property checker for the acceptance filter, bound to the top module.
module arinc_word_filter_chk #(
    parameter int LABEL_W = 8,
    parameter int WORD_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WORD_W-1:0]  word_in,
    input logic               word_eos,
    input logic               decode_en,
    input logic [1:0]         decode_bits,
    input logic               lbl_mode,
    input logic [LABEL_W-1:0] lbl_rdata,
    input logic               fifo_full,
    input logic               fifo_wr,
    input logic [WORD_W-1:0]  fifo_data
);
    p_wr_follows_eos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(word_eos));

    p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !$past(fifo_full));

    p_flag_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_data[WORD_W-1] == ~(^$past(word_in))));

    p_body_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_data[WORD_W-2:0] == $past(word_in[WORD_W-2:0])));

    p_decode_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && $past(decode_en)) |->
            (fifo_data[LABEL_W+1:LABEL_W] == $past(decode_bits)));

    p_table_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lbl_mode && !$past(lbl_mode)) |-> $stable(lbl_rdata));
endmodule

bind arinc_word_filter arinc_word_filter_chk #(.LABEL_W(LABEL_W), .WORD_W(WORD_W)) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_in     (word_in),
    .word_eos    (word_eos),
    .decode_en   (decode_en),
    .decode_bits (decode_bits),
    .lbl_mode    (lbl_mode),
    .lbl_rdata   (lbl_rdata),
    .fifo_full   (fifo_full),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data)
);

// File: tb/test_arinc_word_filter.sv
`timescale 1ns/1ps
module test_arinc_word_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] word_in;
    logic        word_eos;
    logic        label_chk_en;
    logic        decode_en;
    logic [1:0]  decode_bits;
    logic        lbl_mode;
    logic        lbl_wr;
    logic        lbl_rd;
    logic [7:0]  lbl_wdata;
    logic [7:0]  lbl_rdata;
    logic        fifo_full;
    logic        fifo_wr;
    logic [31:0] fifo_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [31:0] exp_q[$];

    always #2.5 clk = ~clk;

    arinc_word_filter i_arinc_word_filter (
        .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_eos(word_eos),
        .label_chk_en(label_chk_en), .decode_en(decode_en), .decode_bits(decode_bits),
        .lbl_mode(lbl_mode), .lbl_wr(lbl_wr), .lbl_rd(lbl_rd),
        .lbl_wdata(lbl_wdata), .lbl_rdata(lbl_rdata),
        .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [7:0] lab, input logic b9,
                                        input logic b10, input logic [21:0] hi);
        return {hi, b10, b9, lab};
    endfunction

    // Driver: strobe one word, queue its expected stored form, check the strobe.
    task automatic send(input logic [31:0] w, input bit exp_pass, input string req);
        @(negedge clk);
        word_in  = w;
        word_eos = 1'b1;
        if (exp_pass) exp_q.push_back({~(^w), w[30:0]});
        @(negedge clk);
        word_eos = 1'b0;
        chk(fifo_wr == exp_pass, req, "fifo write", {31'd0, fifo_wr}, {31'd0, exp_pass});
    endtask

    task automatic lwrite(input logic [7:0] v);
        @(negedge clk);
        lbl_wdata = v;
        lbl_wr    = 1'b1;
        @(negedge clk);
        lbl_wr = 1'b0;
    endtask

    task automatic lread(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(lbl_rdata == exp, req, "label read", {24'd0, lbl_rdata}, {24'd0, exp});
        lbl_rd = 1'b1;
        @(negedge clk);
        lbl_rd = 1'b0;
    endtask

    // Monitor: every FIFO write must match the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected write", fifo_data, 32'd0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(fifo_data == e, "R8", "stored word", fifo_data, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] w1;
        rst_n = 1'b0; word_in = '0; word_eos = 0; label_chk_en = 0; decode_en = 0;
        decode_bits = 2'b00; lbl_mode = 0; lbl_wr = 0; lbl_rd = 0; lbl_wdata = '0;
        fifo_full = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_wr == 1'b0, "R9", "reset write", {31'd0, fifo_wr}, 32'd0);
        chk(lbl_rdata == 8'h00, "R1", "reset entry", {24'd0, lbl_rdata}, 32'd0);

        // R1 R2: fill the table, pointer wraps, read back all entries.
        lbl_mode = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) lwrite(8'h40 + 8'(i));
        for (int i = 0; i < 16; i++) lread(8'h40 + 8'(i), "R1");
        for (int i = 0; i < 3; i++) lread(8'h40 + 8'(i), "R2");

        // R4: strobes outside label mode change nothing.
        @(negedge clk);
        lbl_mode = 1'b0;
        lwrite(8'hFF);
        @(negedge clk);
        lbl_rd = 1'b1;
        @(negedge clk);
        lbl_rd = 1'b0;
        chk(lbl_rdata == 8'h43, "R4", "pointer held", {24'd0, lbl_rdata}, 32'h43);

        // R3: re-entry clears the pointer; entry 3 still unchanged (R4).
        lbl_mode = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) lread(8'h40 + 8'(i), (i == 0) ? "R3" : "R4");
        lbl_mode = 1'b0;
        @(negedge clk);

        // R5 disabled checks, R8 both parities.
        w1 = mkw(8'h05, 1'b0, 1'b1, 22'h01234);
        send(w1, 1, "R5");
        send(w1 ^ 32'h0000_1000, 1, "R8");
        send(w1 ^ 32'h8000_0000, 1, "R8");
        send(32'h0000_0000, 1, "R8");

        // R5 label check on.
        label_chk_en = 1'b1;
        send(mkw(8'h4A, 1'b1, 1'b0, 22'h2AAAA), 1, "R5");
        send(mkw(8'h4F, 1'b0, 1'b0, 22'h00001), 1, "R5");
        send(mkw(8'h3F, 1'b0, 1'b0, 22'h00002), 0, "R5");
        send(mkw(8'hFF, 1'b0, 1'b0, 22'h00003), 0, "R4");
        send(mkw(8'h00, 1'b0, 1'b0, 22'h00004), 0, "R5");
        label_chk_en = 1'b0;

        // R6 decode check: bit 10 must be 1, bit 9 must be 0.
        decode_en = 1'b1;
        decode_bits = 2'b10;
        send(mkw(8'h11, 1'b0, 1'b1, 22'h15555), 1, "R6");
        send(mkw(8'h11, 1'b1, 1'b1, 22'h15555), 0, "R6");
        send(mkw(8'h11, 1'b0, 1'b0, 22'h15555), 0, "R6");

        // R7 both checks.
        label_chk_en = 1'b1;
        send(mkw(8'h41, 1'b0, 1'b1, 22'h0F0F0), 1, "R7");
        send(mkw(8'h41, 1'b1, 1'b0, 22'h0F0F0), 0, "R7");
        send(mkw(8'h31, 1'b0, 1'b1, 22'h0F0F0), 0, "R7");
        label_chk_en = 1'b0;
        decode_en = 1'b0;

        // R10: full blocks the write.
        fifo_full = 1'b1;
        send(mkw(8'h22, 1'b1, 1'b1, 22'h3FFFF), 0, "R10");
        fifo_full = 1'b0;

        // R9: write lasts exactly one cycle.
        send(mkw(8'h23, 1'b1, 1'b1, 22'h00777), 1, "R9");
        @(negedge clk);
        chk(fifo_wr == 1'b0, "R9", "single pulse", {31'd0, fifo_wr}, 32'd0);

        // R5 coincidence: label write and word strobe in the same cycle.
        label_chk_en = 1'b1;
        lbl_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        lbl_wdata = 8'h77;
        lbl_wr = 1'b1;
        word_in = mkw(8'h77, 1'b0, 1'b0, 22'h01010);
        word_eos = 1'b1;
        @(negedge clk);
        lbl_wr = 1'b0;
        word_eos = 1'b0;
        chk(fifo_wr == 1'b0, "R5", "same-cycle old table", {31'd0, fifo_wr}, 32'd0);
        send(mkw(8'h77, 1'b0, 1'b0, 22'h01010), 1, "R5");
        send(mkw(8'h40, 1'b0, 1'b0, 22'h01010), 0, "R5");
        lbl_mode = 1'b0;
        label_chk_en = 1'b0;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "pending words", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule